// File: doc/BRIEF.md
# Serial Transmit FIFO Status Unit

This block sits on the transmit side of a synchronous serial port. It holds one control word for the serializer and queues transmit data words in a FIFO. It also keeps a three-flag status word that software polls or takes interrupts from. Bus writes load the control word and push data words. The serializer takes the control word and pops data words as it shifts them out.

The three flags are control-ready, FIFO-empty and transfer-request. Control-ready means a new control word may be written without loss. FIFO-empty means no data words are queued. Transfer-request means the FIFO's free space is above a programmable watermark.

The flags only carry meaning while transmit is enabled, and they read 0 otherwise. Each flag has its own enable bit. The enabled flags are ORed onto one of two level interrupts. The flags and interrupts are registers, and they update on the same edge as the event that changes them.

Top module: `txs_status_unit`

## Requirements
- R1: `status_o` carries control-ready at bit 14, FIFO-empty at bit 13 and transfer-request at bit 12. Every other bit, including reserved bit 15, is always 0. After `rst_ni` is released, all flags and both interrupts are 0.
- R2: A cycle with `soft_rst_i` high clears all flags and both interrupts at that edge. It also empties the FIFO and drops any pending control word, so with transmit enabled the next edge shows control-ready=1, empty=1 and request=1.
- R3: After any edge at which `tx_en_i` is 0, all three flags and both interrupts read 0, whatever `irq_en_i` holds.
- R4: A control write (`ctl_wr_i`) clears control-ready at that edge. When the serializer takes the pending word (`ctl_take_i` without a write), control-ready reads 1 from the next edge on.
- R5: A control write while control-ready is 0 replaces the pending word. `ctl_data_o` shows only the newest written value, and the earlier value is lost.
- R6: FIFO-empty is 1 while the FIFO holds no words. A data write (`dat_wr_i`) clears it at that edge, and popping the last word sets it again.
- R7: Transfer-request is 1 exactly when the free space (16 minus words held) is strictly greater than the threshold selected by `wm_sel_i`. The encodings are 0→1, 1→4, 2→8 and 3→12 entries. Free space equal to the threshold gives 0.
- R8: A data write while the FIFO holds 16 words is dropped. The stored words and their order are unchanged, and no extra word appears later.
- R9: `dat_rdata_o` shows the oldest held word, and words leave in write order on `dat_pop_i`. A pop while the FIFO is empty has no effect.
- R10: `irq_en_i` bit 0 enables control-ready and bit 1 enables FIFO-empty onto `ctl_irq_o`. Bit 2 enables transfer-request onto `tx_irq_o`. Each interrupt is the OR of its enabled flags, registered on the same edge as the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| soft_rst_i | input | 1 | Synchronous software reset |
| tx_en_i | input | 1 | Transmit enable |
| wm_sel_i | input | 2 | Free-space watermark select |
| irq_en_i | input | 3 | Interrupt enables {request, empty, control-ready} |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 16 | Control word write data |
| ctl_take_i | input | 1 | Serializer takes the pending control word |
| ctl_data_o | output | 16 | Control word held for the serializer |
| dat_wr_i | input | 1 | Data FIFO write strobe |
| dat_wdata_i | input | 16 | Data FIFO write data |
| dat_pop_i | input | 1 | Serializer pops the oldest data word |
| dat_rdata_o | output | 16 | Oldest data word in the FIFO |
| status_o | output | 16 | Status word |
| ctl_irq_o | output | 1 | Control interrupt level |
| tx_irq_o | output | 1 | Transmit interrupt level |

## Verification
The assertions assume that all strobes are synchronous to `clk_i` and stable around its rising edge. They also assume `irq_en_i` is sampled on the same edge as the flags, since the interrupt checks compare each interrupt with the flags and the enables from the previous cycle. The stimulus changes every input only on the falling edge. It keeps `soft_rst_i` as a single-cycle pulse and avoids overlapping a control write with a take, except where overwrite behaviour is the point of the test.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int unsigned STAT_W  = 16;
  localparam int unsigned RDY_BIT = 14;
  localparam int unsigned EMP_BIT = 13;
  localparam int unsigned REQ_BIT = 12;
  localparam int unsigned IE_RDY  = 0;
  localparam int unsigned IE_EMP  = 1;
  localparam int unsigned IE_REQ  = 2;

  typedef struct packed {
    logic rdy;
    logic emp;
    logic req;
  } txs_flags_t;

  function automatic int unsigned wm_thresh(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return (depth * 3) / 4;
    endcase
  endfunction
endpackage

// File: rtl/txs_ctl_hold.sv
module txs_ctl_hold #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] data_o,
  output logic              pend_d_o
);
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] data_q;

  // a write always wins over a take in the same cycle
  always_comb begin
    pend_d = pend_q;
    if (clr_i)       pend_d = 1'b0;
    else if (wr_i)   pend_d = 1'b1;
    else if (take_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (wr_i && !clr_i) data_q <= wdata_i;
    end
  end

  assign data_o   = data_q;
  assign pend_d_o = pend_d;
endmodule

// File: rtl/txs_fifo.sv
module txs_fifo #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  cnt_d_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [AW-1:0]    LAST_PTR = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wr_ok, rd_ok;

  // full is judged on the count before the edge
  assign wr_ok = wr_i && (cnt_q != FULL_CNT) && !clr_i;
  assign rd_ok = pop_i && (cnt_q != '0) && !clr_i;

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + CNT_W'(wr_ok) - CNT_W'(rd_ok);
  end

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (clr_i) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
      end else begin
        if (wr_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
        if (rd_ok) rd_ptr_q <= ptr_inc(rd_ptr_q);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign cnt_d_o = cnt_d;
endmodule

// File: rtl/txs_flags.sv
module txs_flags
  import txs_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tx_en_i,
  input  logic [1:0]       wm_sel_i,
  input  logic [2:0]       irq_en_i,
  input  logic             pend_d_i,
  input  logic [CNT_W-1:0] cnt_d_i,
  output txs_flags_t       flags_o,
  output logic             ctl_irq_o,
  output logic             tx_irq_o
);
  txs_flags_t flags_q, flags_d;
  logic       ctl_irq_q, tx_irq_q, ctl_irq_d, tx_irq_d;
  int unsigned free_n, thr;

  always_comb begin
    free_n    = DEPTH - int'(cnt_d_i);
    thr       = wm_thresh(wm_sel_i, DEPTH);
    flags_d   = '0;
    if (tx_en_i && !clr_i) begin
      flags_d.rdy = !pend_d_i;
      flags_d.emp = (cnt_d_i == '0);
      flags_d.req = (free_n > thr);
    end
    ctl_irq_d = (flags_d.rdy && irq_en_i[IE_RDY]) || (flags_d.emp && irq_en_i[IE_EMP]);
    tx_irq_d  = flags_d.req && irq_en_i[IE_REQ];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q   <= '0;
      ctl_irq_q <= 1'b0;
      tx_irq_q  <= 1'b0;
    end else begin
      flags_q   <= flags_d;
      ctl_irq_q <= ctl_irq_d;
      tx_irq_q  <= tx_irq_d;
    end
  end

  assign flags_o   = flags_q;
  assign ctl_irq_o = ctl_irq_q;
  assign tx_irq_o  = tx_irq_q;
endmodule

// File: rtl/txs_status_unit.sv
module txs_status_unit
  import txs_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              tx_en_i,
  input  logic [1:0]        wm_sel_i,
  input  logic [2:0]        irq_en_i,
  input  logic              ctl_wr_i,
  input  logic [DATA_W-1:0] ctl_wdata_i,
  input  logic              ctl_take_i,
  output logic [DATA_W-1:0] ctl_data_o,
  input  logic              dat_wr_i,
  input  logic [DATA_W-1:0] dat_wdata_i,
  input  logic              dat_pop_i,
  output logic [DATA_W-1:0] dat_rdata_o,
  output logic [STAT_W-1:0] status_o,
  output logic              ctl_irq_o,
  output logic              tx_irq_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             pend_d;
  logic [CNT_W-1:0] cnt_d;
  txs_flags_t       flags;

  txs_ctl_hold #(.DATA_W(DATA_W)) u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (soft_rst_i),
    .wr_i     (ctl_wr_i),
    .wdata_i  (ctl_wdata_i),
    .take_i   (ctl_take_i),
    .data_o   (ctl_data_o),
    .pend_d_o (pend_d)
  );

  txs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (soft_rst_i),
    .wr_i    (dat_wr_i),
    .wdata_i (dat_wdata_i),
    .pop_i   (dat_pop_i),
    .rdata_o (dat_rdata_o),
    .cnt_d_o (cnt_d)
  );

  txs_flags #(.DEPTH(DEPTH)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (soft_rst_i),
    .tx_en_i   (tx_en_i),
    .wm_sel_i  (wm_sel_i),
    .irq_en_i  (irq_en_i),
    .pend_d_i  (pend_d),
    .cnt_d_i   (cnt_d),
    .flags_o   (flags),
    .ctl_irq_o (ctl_irq_o),
    .tx_irq_o  (tx_irq_o)
  );

  always_comb begin
    status_o          = '0;
    status_o[RDY_BIT] = flags.rdy;
    status_o[EMP_BIT] = flags.emp;
    status_o[REQ_BIT] = flags.req;
  end
endmodule

// File: rtl/txs_status_unit_chk.sv
module txs_status_unit_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              tx_en_i,
  input logic [2:0]        irq_en_i,
  input logic              ctl_wr_i,
  input logic [DATA_W-1:0] ctl_wdata_i,
  input logic              ctl_take_i,
  input logic [DATA_W-1:0] ctl_data_o,
  input logic              dat_wr_i,
  input logic [15:0]       status_o,
  input logic              ctl_irq_o,
  input logic              tx_irq_o
);
  // R1
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[15] == 1'b0 && status_o[11:0] == '0);

  // R2
  soft_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (status_o[14:12] == 3'b000) && !ctl_irq_o && !tx_irq_o);

  // R3
  tx_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> (status_o[14:12] == 3'b000) && !ctl_irq_o && !tx_irq_o);

  // R4
  ctl_wr_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr_i |=> !status_o[14]);

  // R4
  ctl_take_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_take_i && !ctl_wr_i && tx_en_i && !soft_rst_i) |=> status_o[14]);

  // R5
  ctl_newest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && !soft_rst_i) |=> ctl_data_o == $past(ctl_wdata_i));

  // R6
  dat_wr_clears_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_wr_i |=> !status_o[13]);

  // R10
  ctl_irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_irq_o == ((status_o[14] && $past(irq_en_i[0])) || (status_o[13] && $past(irq_en_i[1]))));

  // R10
  tx_irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o == (status_o[12] && $past(irq_en_i[2])));
endmodule

bind txs_status_unit txs_status_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .soft_rst_i  (soft_rst_i),
  .tx_en_i     (tx_en_i),
  .irq_en_i    (irq_en_i),
  .ctl_wr_i    (ctl_wr_i),
  .ctl_wdata_i (ctl_wdata_i),
  .ctl_take_i  (ctl_take_i),
  .ctl_data_o  (ctl_data_o),
  .dat_wr_i    (dat_wr_i),
  .status_o    (status_o),
  .ctl_irq_o   (ctl_irq_o),
  .tx_irq_o    (tx_irq_o)
);

// File: tb/txs_status_unit_tb.sv
`timescale 1ns/1ps
module txs_status_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic        tx_en_i = 1'b0;
  logic [1:0]  wm_sel_i = '0;
  logic [2:0]  irq_en_i = '0;
  logic        ctl_wr_i = 1'b0;
  logic [15:0] ctl_wdata_i = '0;
  logic        ctl_take_i = 1'b0;
  logic [15:0] ctl_data_o;
  logic        dat_wr_i = 1'b0;
  logic [15:0] dat_wdata_i = '0;
  logic        dat_pop_i = 1'b0;
  logic [15:0] dat_rdata_o;
  logic [15:0] status_o;
  logic        ctl_irq_o, tx_irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  txs_status_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i), .tx_en_i(tx_en_i),
    .wm_sel_i(wm_sel_i), .irq_en_i(irq_en_i), .ctl_wr_i(ctl_wr_i),
    .ctl_wdata_i(ctl_wdata_i), .ctl_take_i(ctl_take_i), .ctl_data_o(ctl_data_o),
    .dat_wr_i(dat_wr_i), .dat_wdata_i(dat_wdata_i), .dat_pop_i(dat_pop_i),
    .dat_rdata_o(dat_rdata_o), .status_o(status_o), .ctl_irq_o(ctl_irq_o),
    .tx_irq_o(tx_irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  function automatic int thr_of(input logic [1:0] wm);
    case (wm)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 12;
    endcase
  endfunction

  task automatic soft_pulse();
    soft_rst_i = 1'b1; tick(); soft_rst_i = 1'b0;
  endtask

  task automatic push(input logic [15:0] v);
    dat_wr_i = 1'b1; dat_wdata_i = v; tick(); dat_wr_i = 1'b0;
  endtask

  task automatic pop();
    dat_pop_i = 1'b1; tick(); dat_pop_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset status", status_o, 32'h0);
    chk("R1 reset ctl_irq", ctl_irq_o, 1'b0);
    chk("R1 reset tx_irq", tx_irq_o, 1'b0);
  endtask

  task automatic t_enable();
    tx_en_i = 1'b1; tick();
    chk("R1 enabled status layout", status_o, 32'h7000);
  endtask

  task automatic t_ctl();
    ctl_wr_i = 1'b1; ctl_wdata_i = 16'hA5A5; tick(); ctl_wr_i = 1'b0;
    chk("R4 write clears ready", status_o[14], 1'b0);
    chk("R5 first control value", ctl_data_o, 16'hA5A5);
    ctl_wr_i = 1'b1; ctl_wdata_i = 16'h1234; tick(); ctl_wr_i = 1'b0;
    chk("R5 overwrite replaces", ctl_data_o, 16'h1234);
    chk("R5 still not ready", status_o[14], 1'b0);
    tick();
    chk("R4 no take keeps not ready", status_o[14], 1'b0);
    ctl_take_i = 1'b1; tick(); ctl_take_i = 1'b0;
    chk("R4 ready after take", status_o[14], 1'b1);
    chk("R5 value kept after take", ctl_data_o, 16'h1234);
  endtask

  task automatic t_fill(input logic [1:0] wm);
    wm_sel_i = wm;
    soft_pulse();
    tick();
    chk("R6 empty after clear", status_o[13], 1'b1);
    chk("R7 request at free 16", status_o[12], 1'b1);
    for (int k = 1; k <= 16; k++) begin
      push(16'(k * 16'h0101 + wm));
      chk("R6 empty cleared by write", status_o[13], 1'b0);
      chk("R7 request vs watermark", status_o[12], ((16 - k) > thr_of(wm)) ? 1'b1 : 1'b0);
    end
  endtask

  task automatic t_full_and_order();
    push(16'hDEAD);
    chk("R8 head unchanged after dropped write", dat_rdata_o, 16'h0101);
    for (int k = 1; k <= 16; k++) begin
      chk("R9 FIFO order", dat_rdata_o, 16'(k * 16'h0101));
      pop();
    end
    chk("R8 no extra word after drain", status_o[13], 1'b1);
    chk("R6 empty after last pop", status_o[13], 1'b1);
    pop();
    chk("R9 pop on empty keeps empty", status_o[13], 1'b1);
    push(16'h4242);
    chk("R9 head after empty pop", dat_rdata_o, 16'h4242);
    chk("R6 one word not empty", status_o[13], 1'b0);
    pop();
    chk("R6 empty again", status_o[13], 1'b1);
  endtask

  task automatic t_irq();
    irq_en_i = 3'b000; tick();
    chk("R10 no enables ctl", ctl_irq_o, 1'b0);
    chk("R10 no enables tx", tx_irq_o, 1'b0);
    irq_en_i = 3'b010; tick();
    chk("R10 empty enable ctl", ctl_irq_o, 1'b1);
    chk("R10 empty enable tx", tx_irq_o, 1'b0);
    irq_en_i = 3'b100; tick();
    chk("R10 request enable ctl", ctl_irq_o, 1'b0);
    chk("R10 request enable tx", tx_irq_o, 1'b1);
    irq_en_i = 3'b001; tick();
    chk("R10 ready enable ctl", ctl_irq_o, 1'b1);
    ctl_wr_i = 1'b1; ctl_wdata_i = 16'h0F0F; tick(); ctl_wr_i = 1'b0;
    chk("R10 ready cleared drops ctl irq", ctl_irq_o, 1'b0);
    ctl_take_i = 1'b1; tick(); ctl_take_i = 1'b0;
    chk("R10 ready back raises ctl irq", ctl_irq_o, 1'b1);
  endtask

  task automatic t_tx_off();
    irq_en_i = 3'b111; tx_en_i = 1'b0; tick();
    chk("R3 flags zero when disabled", status_o, 32'h0);
    chk("R3 ctl irq low when disabled", ctl_irq_o, 1'b0);
    chk("R3 tx irq low when disabled", tx_irq_o, 1'b0);
    tx_en_i = 1'b1; tick();
    chk("R3 flags return on enable", status_o, 32'h7000);
  endtask

  task automatic t_soft();
    push(16'h5555);
    ctl_wr_i = 1'b1; ctl_wdata_i = 16'h7777; tick(); ctl_wr_i = 1'b0;
    chk("R2 pre-reset status", status_o, 32'h1000);
    soft_pulse();
    chk("R2 soft reset clears flags", status_o, 32'h0);
    chk("R2 soft reset clears ctl irq", ctl_irq_o, 1'b0);
    chk("R2 soft reset clears tx irq", tx_irq_o, 1'b0);
    tick();
    chk("R2 state cleared after soft reset", status_o, 32'h7000);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_enable();
    t_ctl();
    for (int w = 0; w < 4; w++) t_fill(2'(w));
    wm_sel_i = 2'd0;
    soft_pulse();
    for (int k = 1; k <= 16; k++) push(16'(k * 16'h0101));
    t_full_and_order();
    t_irq();
    t_tx_off();
    t_soft();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule